// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Read Controller

This block is the host-side master for an external 16-bit sampling converter that is wired over three lines: an active-low select, a data clock that the host generates, and a serial data line returned by the converter. A single start request drops the select line, runs the data clock at a rate derived from the system clock, passes over the converter's input sampling window and its leading null bit, and shifts in up to sixteen result bits. The word is presented as straight binary with a one-cycle valid pulse.

The caller chooses how many result bits to read on each frame. A short frame raises the select line as soon as the requested bits have arrived. This saves converter power when only a coarse reading is needed, and the low-order bits that were not received read as zero. The half-period of the data clock is a run-time input. It is sampled when a frame is accepted and is raised to a floor set by a parameter, so that the converter's maximum clock rate and minimum phase width are never exceeded. Between frames the select line stays high for at least one full data-clock period before another start request can be accepted.

Top module: `sar_serial_reader`

## Requirements
- R1: After reset, adcCsN is 1, adcSclk is 0, busy is 0 and resultValid is 0.
- R2: When busy is 0, a startReq seen at a clock edge is accepted. From the next cycle adcCsN is 0, busy is 1 and adcSclk is still 0. Every data-clock cycle then starts with its low phase.
- R3: Each high phase and each low phase of adcSclk lasts h system cycles, where h = max(halfDiv, MIN_HALF). The value of h is taken when the frame is accepted, and later changes to halfDiv have no effect on the frame in progress.
- R4: The first five rising edges of adcSclk in a frame fall in the sampling window and are discarded. The sixth rising edge carries the null bit and is discarded. Rising edges 7 to 6+n capture result bits from the most significant bit down, each taken from adcSdo as the edge occurs.
- R5: A frame contains exactly 6+n rising edges of adcSclk. adcCsN goes high, with adcSclk low, at the end of the high phase that follows rising edge 6+n, so adcCsN is low for exactly (6+n)*2h cycles.
- R6: n equals bitCount for values 1 to 16. A bitCount of 0 or greater than 16 gives n = 16. Result bits below the n received bits read as 0.
- R7: resultValid is a one-cycle pulse in the same cycle that adcCsN rises. resultData carries the new word from that cycle and holds it until the next pulse.
- R8: After adcCsN rises it stays high for at least 2h cycles, and busy stays high until this gap has elapsed. A startReq while busy is 1 is ignored and does not produce an extra frame.
- R9: adcSclk is 0 whenever adcCsN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a conversion frame |
| bitCount | input | 5 | Number of result bits to read (0 or above 16 means 16) |
| halfDiv | input | DIV_W | Requested data-clock half-period in system cycles |
| adcSdo | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Active-low converter select |
| adcSclk | output | 1 | Generated data clock |
| busy | output | 1 | Frame or inter-frame gap in progress |
| resultValid | output | 1 | One-cycle pulse when a result is published |
| resultData | output | 16 | Straight-binary result, MSB-aligned |

## Verification
The bench builds the block with DIV_W = 6 and MIN_HALF = 3. With these values the half-period floor can be reached from ordinary inputs: requests of 0, 1 and 2 are all raised to 3, while 4 to 7 pass through unchanged. Frames stay a few hundred cycles long, so short frames, full frames, the out-of-range bit counts, a change to the divider in the middle of a frame and a start request during a frame all fit in one run. A behavioural converter model in the bench drives a junk value of 1 during the sampling window, a 0 for the null bit, and then the word MSB-first followed by LSB-first. An off-by-one in edge counting therefore shows up as a wrong result word.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  // Result resolution of the converter and the fixed framing around it
  localparam int WORD_W       = 16;
  localparam int SAMPLE_EDGES = 5;                          // rising edges in sampling window
  localparam int NULL_EDGE    = SAMPLE_EDGES + 1;           // edge carrying the null bit
  localparam int FIRST_DATA   = NULL_EDGE + 1;              // edge carrying the MSB
  localparam int LAST_MAX     = NULL_EDGE + WORD_W;         // last edge of a full frame

  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int EDGE_W = $clog2(LAST_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_GUARD = 2'd3
  } frameState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             clearWord;
    logic             captureBit;
    logic [IDX_W-1:0] bitPos;
    logic             publish;
  } dpStrobe_t;

endpackage

// File: rtl/sar_rd_timer.sv
module sar_rd_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [TW-1:0] loadVal,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DIV_W    = 13,
  parameter int MIN_HALF = 52,
  localparam int TW      = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             timerExpired,
  output logic             timerLoad,
  output logic [TW-1:0]    timerVal,
  output dpStrobe_t        strobe,
  output logic             csN,
  output logic             sclk,
  output logic             busy
);

  frameState_t       state, nState;
  logic [DIV_W-1:0]  halfLatch;
  logic [DIV_W-1:0]  halfEff;
  logic [CNT_W-1:0]  nEff;
  logic [EDGE_W-1:0] edgeCnt, edgeNext, lastEdge;
  logic              edgeInc;

  // Clamp the requested half-period to the converter's floor
  assign halfEff = (halfDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : halfDiv;

  // Out-of-range bit counts select a full-width read
  assign nEff = ((bitCount == '0) || (bitCount > CNT_W'(WORD_W))) ?
                CNT_W'(WORD_W) : bitCount;

  assign edgeNext = edgeCnt + 1'b1;

  always_comb begin
    nState           = state;
    timerLoad        = 1'b0;
    timerVal         = '0;
    edgeInc          = 1'b0;
    strobe           = '0;
    strobe.bitPos    = IDX_W'(EDGE_W'(FIRST_DATA + WORD_W - 1) - edgeNext);
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          nState           = ST_LOW;
          timerLoad        = 1'b1;
          timerVal         = {1'b0, halfEff} - 1'b1;
          strobe.clearWord = 1'b1;
        end
      end
      ST_LOW: begin
        if (timerExpired) begin
          nState    = ST_HIGH;
          timerLoad = 1'b1;
          timerVal  = {1'b0, halfLatch} - 1'b1;
          edgeInc   = 1'b1;
          if (edgeNext >= EDGE_W'(FIRST_DATA)) begin
            strobe.captureBit = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (timerExpired) begin
          timerLoad = 1'b1;
          if (edgeCnt == lastEdge) begin
            nState         = ST_GUARD;
            timerVal       = {halfLatch, 1'b0} - 1'b1;
            strobe.publish = 1'b1;
          end else begin
            nState   = ST_LOW;
            timerVal = {1'b0, halfLatch} - 1'b1;
          end
        end
      end
      ST_GUARD: begin
        if (timerExpired) begin
          nState = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfLatch <= DIV_W'(MIN_HALF);
      lastEdge  <= EDGE_W'(LAST_MAX);
      edgeCnt   <= '0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
    end else begin
      state <= nState;
      csN   <= !((nState == ST_LOW) || (nState == ST_HIGH));
      sclk  <= (nState == ST_HIGH);
      if ((state == ST_IDLE) && startReq) begin
        halfLatch <= halfEff;
        lastEdge  <= EDGE_W'(NULL_EDGE) + EDGE_W'(nEff);
        edgeCnt   <= '0;
      end else if (edgeInc) begin
        edgeCnt <= edgeNext;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sar_rd_datapath.sv
module sar_rd_datapath
  import sar_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdoIn,
  output logic              resultValid,
  output logic [WORD_W-1:0] resultData
);

  logic [WORD_W-1:0] shiftWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord   <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.publish;
      if (strobe.clearWord) begin
        shiftWord <= '0;
      end else if (strobe.captureBit) begin
        shiftWord[strobe.bitPos] <= sdoIn;
      end
      if (strobe.publish) begin
        resultData <= shiftWord;
      end
    end
  end

endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
  import sar_rd_pkg::*;
#(
  parameter int DIV_W    = 13,
  parameter int MIN_HALF = 52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              adcSdo,
  output logic              adcCsN,
  output logic              adcSclk,
  output logic              busy,
  output logic              resultValid,
  output logic [WORD_W-1:0] resultData
);

  localparam int TW = DIV_W + 1;

  dpStrobe_t     strobe;
  logic          timerLoad;
  logic [TW-1:0] timerVal;
  logic          timerExpired;

  sar_rd_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .load    (timerLoad),
    .loadVal (timerVal),
    .expired (timerExpired)
  );

  sar_rd_ctrl #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .bitCount     (bitCount),
    .halfDiv      (halfDiv),
    .timerExpired (timerExpired),
    .timerLoad    (timerLoad),
    .timerVal     (timerVal),
    .strobe       (strobe),
    .csN          (adcCsN),
    .sclk         (adcSclk),
    .busy         (busy)
  );

  sar_rd_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sdoIn       (adcSdo),
    .resultValid (resultValid),
    .resultData  (resultData)
  );

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
  parameter int MIN_HALF = 52
) (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic adcCsN,
  input logic adcSclk,
  input logic busy,
  input logic resultValid
);

  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
    end else if (adcSclk) begin
      if (hiCnt != 16'hFFFF) hiCnt <= hiCnt + 1'b1;
    end else begin
      hiCnt <= '0;
    end
  end

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> !adcSclk);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (!adcCsN && busy && !adcSclk));

  p_high_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcSclk) |-> (hiCnt >= 16'(MIN_HALF)));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_valid_on_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCsN) |-> resultValid);

  p_end_on_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(adcCsN));

  p_busy_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    !adcCsN |-> busy);

endmodule

bind sar_serial_reader sar_rd_checker #(.MIN_HALF(MIN_HALF)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .adcCsN      (adcCsN),
  .adcSclk     (adcSclk),
  .busy        (busy),
  .resultValid (resultValid)
);

// File: tb/sar_serial_reader_tb.sv
module sar_serial_reader_tb;

  localparam int DIV_W    = 6;
  localparam int MIN_HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [4:0]  bitCount = '0;
  logic [DIV_W-1:0] halfDiv = '0;
  logic        adcSdo = 1'b1;
  logic        adcCsN, adcSclk, busy, resultValid;
  logic [15:0] resultData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sar_serial_reader #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_dut (
    .clk, .rstN, .startReq, .bitCount, .halfDiv, .adcSdo,
    .adcCsN, .adcSclk, .busy, .resultValid, .resultData
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model: updates after each falling data-clock edge
  logic [15:0] adcCode = '0;
  logic        prevSclk = 1'b0;
  int          fallCnt = 0;
  always @(negedge clk) begin
    if (adcCsN) begin
      fallCnt = 0;
      adcSdo  = 1'b1;
    end else if (prevSclk && !adcSclk) begin
      fallCnt = fallCnt + 1;
      if (fallCnt < 5)       adcSdo = 1'b1;
      else if (fallCnt == 5) adcSdo = 1'b0;
      else if (fallCnt < 22) adcSdo = adcCode[21 - fallCnt];
      else if (fallCnt < 38) adcSdo = adcCode[fallCnt - 22];
      else                   adcSdo = 1'b1;
    end
    prevSclk = adcSclk;
  end

  // Scoreboard
  typedef struct {
    logic [15:0] data;
    int          rises;
    int          lowLen;
    int          half;
  } expItem_t;
  expItem_t expQ[$];

  int framesStarted = 0;
  int csFalls = 0;
  bit sclkIdleBad = 1'b0;

  task automatic runFrame(input logic [15:0] code, input logic [4:0] nb,
                          input logic [DIV_W-1:0] div, input bit disturb);
    expItem_t it;
    int h, n;
    logic [15:0] mask;
    @(negedge clk);
    while (busy) @(negedge clk);
    h = (int'(div) < MIN_HALF) ? MIN_HALF : int'(div);
    n = (nb == 0 || nb > 16) ? 16 : int'(nb);
    mask = 16'hFFFF << (16 - n);
    it.data = code & mask;
    it.rises = 6 + n;
    it.lowLen = (6 + n) * 2 * h;
    it.half = h;
    expQ.push_back(it);
    adcCode = code; bitCount = nb; halfDiv = div;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    framesStarted++;
    check(!adcCsN && busy && !adcSclk, "R2", "accept state {cs,busy,sclk}",
          {adcCsN, busy, adcSclk}, 3'b010);
    if (disturb) begin
      repeat (10) @(negedge clk);
      halfDiv = 6'd1;                 // R3: must not affect this frame
      startReq = 1'b1;                // R8: must be ignored
      @(negedge clk);
      startReq = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // Monitor
  int  lowCnt = 0, riseCnt = 0, hiRun = 0, hiMin = 1 << 30, hiMax = 0;
  int  gapCnt = 0, lastHalf = 0;
  bit  haveEnd = 1'b0;
  logic prevCs = 1'b1, prevSc = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (adcCsN && adcSclk) sclkIdleBad = 1'b1;
      if (prevCs && !adcCsN) begin
        csFalls++;
        if (haveEnd)
          check(gapCnt >= 2 * lastHalf, "R8", "select high gap", gapCnt, 2 * lastHalf);
        gapCnt = 0;
      end
      if (!adcCsN) lowCnt++;
      else gapCnt++;
      if (adcSclk && !prevSc) riseCnt++;
      if (adcSclk) hiRun++;
      else if (prevSc) begin
        if (hiRun < hiMin) hiMin = hiRun;
        if (hiRun > hiMax) hiMax = hiRun;
        hiRun = 0;
      end
      if (resultValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected result", int'(resultData), 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(resultData == e.data, "R4 R6", "result word", int'(resultData), int'(e.data));
          check(riseCnt == e.rises, "R5", "rising edges", riseCnt, e.rises);
          check(lowCnt == e.lowLen, "R5", "select low cycles", lowCnt, e.lowLen);
          check(hiMin == e.half && hiMax == e.half, "R3", "high phase width",
                hiMax, e.half);
          check(adcCsN && !adcSclk, "R7", "valid with select rise",
                {adcCsN, adcSclk}, 2'b10);
          lastHalf = e.half;
        end
        haveEnd = 1'b1;
        lowCnt = 0; riseCnt = 0; hiMin = 1 << 30; hiMax = 0;
      end
      if (prevCs == 1'b0 && adcCsN && !resultValid)
        check(1'b0, "R7", "select rose without valid", 0, 1);
    end
    prevCs = adcCsN;
    prevSc = adcSclk;
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(adcCsN && !adcSclk && !busy && !resultValid, "R1", "reset outputs",
          {adcCsN, adcSclk, busy, resultValid}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(adcCsN && !busy, "R1", "idle after reset", {adcCsN, busy}, 2'b10);

    runFrame(16'hA5C3, 5'd16, 6'd4, 1'b0);   // R4 full frame
    runFrame(16'hFFFF, 5'd16, 6'd1, 1'b0);   // R3 clamp 1 -> 3
    runFrame(16'h0000, 5'd0,  6'd5, 1'b0);   // R6 zero count -> 16
    runFrame(16'hB7FF, 5'd3,  6'd3, 1'b0);   // R6 short frame, low bits zero
    runFrame(16'h8001, 5'd1,  6'd0, 1'b0);   // R6 single bit, clamp 0 -> 3
    runFrame(16'h1234, 5'd20, 6'd6, 1'b0);   // R6 count above 16
    runFrame(16'h6C3F, 5'd9,  6'd7, 1'b0);   // R5 nine bits
    runFrame(16'h5AA5, 5'd16, 6'd5, 1'b1);   // R3 latched divider, R8 ignored start
    runFrame(16'h7FFF, 5'd14, 6'd2, 1'b0);   // R3 clamp 2 -> 3
    runFrame(16'h8000, 5'd16, 6'd3, 1'b0);   // R4 midscale

    repeat (5) @(negedge clk);
    check(csFalls == framesStarted, "R8", "frames started", csFalls, framesStarted);
    check(expQ.size() == 0, "R7", "results outstanding", expQ.size(), 0);
    check(!sclkIdleBad, "R9", "clock low while deselected", int'(sclkIdleBad), 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule